// File: doc/BRIEF.md
# Supply monitor interrupt controller

This block turns the digital outputs of several supply comparators into sticky status flags and two interrupt lines. It watches five conditions, already synchronized to the block clock: the battery rail above its upper threshold, the battery rail inside the middle band, the battery rail below its low threshold, and regulator overvoltage and undervoltage. Each condition sets its own flag. Software reads the flags and clears them through a simple 32-bit register port.

An enable register selects which flags drive the outputs. A band-select bit picks whether the upper band or the middle band feeds the battery-range interrupt. That interrupt and the overvoltage source drive the maskable line `irq_o`. The two loss-of-supply sources, regulator undervoltage and low battery, drive the non-maskable line `nmi_o`. A flag whose condition is still present cannot be cleared: it sets again at once.

Top module: `supmon_irq_ctrl`

## Requirements
- R1: After reset, the enable register (offset 0) reads 0x00000000 and both interrupt outputs are low. With the upper-band condition high, the status register (offset 1) reads 0x00002100.
- R2: Only enable bits 10 (battery-range enable), 8 (band select), 2 (overvoltage enable), 1 (undervoltage enable) and 0 (low-battery enable) are writable. Every other enable bit reads 0.
- R3: The status register holds sticky flags at bit 0 (low battery), bit 1 (regulator undervoltage), bit 2 (regulator overvoltage), bit 8 (upper band) and bit 9 (middle band). Each flag sets on any clock edge where its condition is high. Bit 13 (upper band) and bit 14 (middle band) show the live condition, registered once.
- R4: Writing 1 to a sticky status bit clears it when its condition is low. Status bits written with 0 keep their value.
- R5: When a condition is high in the same cycle as a write-one-to-clear of its flag, the flag stays 1.
- R6: `irq_o` is driven by the battery-range source when enable bit 10 is set. With enable bit 8 at 0, the source is the upper-band flag. With enable bit 8 at 1, it is the middle-band flag.
- R7: When enable bit 2 is set, the regulator overvoltage flag drives `irq_o`.
- R8: The regulator undervoltage flag (enable bit 1) and the low-battery flag (enable bit 0) drive `nmi_o` and never `irq_o`. A flag whose enable bit is clear sets in status but drives no output.
- R9: Both interrupt outputs are registered levels. They change one clock after the flag or enable state that causes the change.
- R10: Writes to reserved status bits, to read-only status bits and to unmapped offsets have no effect. A read of an unmapped offset returns 0.
- R11: Read data appears on `rdata_o` in the cycle after the read request. In any cycle with no read request, `rdata_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Register access request |
| we_i | input | 1 | 1 for a write, 0 for a read |
| addr_i | input | 4 | Word offset (0 enable, 1 status) |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, one cycle after the request |
| bat_hi_i | input | 1 | Battery rail above the upper threshold |
| bat_mid_i | input | 1 | Battery rail inside the middle band |
| bat_low_i | input | 1 | Battery rail below the low threshold |
| vreg_ov_i | input | 1 | Regulator overvoltage |
| vreg_uv_i | input | 1 | Regulator undervoltage |
| irq_o | output | 1 | Maskable interrupt |
| nmi_o | output | 1 | Non-maskable interrupt |

## Verification
Several properties are checked on every cycle:
- A high condition forces its flag set on the next edge, even against a clear.
- A clear with the condition low empties the flag.
- The live bits follow their inputs with a one-cycle lag.
- Each output stays low while all of its enables are zero.
- Read data is zero when no read is requested.

Only the bench scenarios show the rest:
- the exact register images;
- the band-select routing;
- the ignored writes to reserved and unmapped locations;
- the one-cycle lag from an enable change to the output level.

// File: rtl/supmon_pkg.sv
package supmon_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 4;

  localparam logic [ADDR_W-1:0] OFS_EN   = 4'd0;
  localparam logic [ADDR_W-1:0] OFS_STAT = 4'd1;

  // enable bit positions
  localparam int EN_LOW  = 0;
  localparam int EN_UV   = 1;
  localparam int EN_OV   = 2;
  localparam int EN_SEL  = 8;
  localparam int EN_BAND = 10;
  localparam logic [DATA_W-1:0] EN_MASK =
    (32'd1 << EN_LOW) | (32'd1 << EN_UV) | (32'd1 << EN_OV) |
    (32'd1 << EN_SEL) | (32'd1 << EN_BAND);

  // sticky source indices
  localparam int SRC_LOW = 0;
  localparam int SRC_UV  = 1;
  localparam int SRC_OV  = 2;
  localparam int SRC_HI  = 3;
  localparam int SRC_MID = 4;
  localparam int NUM_SRC = 5;

  // live status positions
  localparam int LIVE_HI_POS  = 13;
  localparam int LIVE_MID_POS = 14;

  function automatic int src_pos(input int s);
    case (s)
      SRC_LOW: return 0;
      SRC_UV:  return 1;
      SRC_OV:  return 2;
      SRC_HI:  return 8;
      default: return 9;
    endcase
  endfunction

  function automatic logic src_rst(input int s);
    return (s == SRC_HI);
  endfunction
endpackage

// File: rtl/supmon_flag.sv
module supmon_flag #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flag_o <= RST_VAL;
    else if (set_i)  flag_o <= 1'b1;  // set wins over clear
    else if (clr_i)  flag_o <= 1'b0;
  end
endmodule

// File: rtl/supmon_en_reg.sv
module supmon_en_reg
  import supmon_pkg::*;
#(
  parameter logic [DATA_W-1:0] MASK = EN_MASK
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] en_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   en_o <= '0;
    else if (wr_i) en_o <= wdata_i & MASK;
  end
endmodule

// File: rtl/supmon_irq_route.sv
module supmon_irq_route
  import supmon_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] en_i,
  input  logic [NUM_SRC-1:0] flags_i,
  output logic              irq_o,
  output logic              nmi_o
);
  logic band_flag, irq_d, nmi_d;

  always_comb begin
    band_flag = en_i[EN_SEL] ? flags_i[SRC_MID] : flags_i[SRC_HI];
    irq_d     = (en_i[EN_BAND] & band_flag) | (en_i[EN_OV] & flags_i[SRC_OV]);
    nmi_d     = (en_i[EN_UV] & flags_i[SRC_UV]) | (en_i[EN_LOW] & flags_i[SRC_LOW]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_o <= 1'b0;
      nmi_o <= 1'b0;
    end else begin
      irq_o <= irq_d;
      nmi_o <= nmi_d;
    end
  end
endmodule

// File: rtl/supmon_irq_ctrl.sv
module supmon_irq_ctrl
  import supmon_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              bat_hi_i,
  input  logic              bat_mid_i,
  input  logic              bat_low_i,
  input  logic              vreg_ov_i,
  input  logic              vreg_uv_i,
  output logic              irq_o,
  output logic              nmi_o
);
  logic wr_en, wr_stat, rd_req;
  logic [DATA_W-1:0]  en_q, stat_img, rd_val;
  logic [NUM_SRC-1:0] cond, flags_q;
  logic [1:0]         live_q;  // [0] upper band, [1] middle band

  assign wr_en   = req_i & we_i & (addr_i == OFS_EN);
  assign wr_stat = req_i & we_i & (addr_i == OFS_STAT);
  assign rd_req  = req_i & ~we_i;

  always_comb begin
    cond          = '0;
    cond[SRC_LOW] = bat_low_i;
    cond[SRC_UV]  = vreg_uv_i;
    cond[SRC_OV]  = vreg_ov_i;
    cond[SRC_HI]  = bat_hi_i;
    cond[SRC_MID] = bat_mid_i;
  end

  supmon_en_reg u_en (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (wr_en),
    .wdata_i(wdata_i),
    .en_o   (en_q)
  );

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_flag
    localparam int POS = src_pos(g);
    supmon_flag #(.RST_VAL(src_rst(g))) u_flag (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .set_i (cond[g]),
      .clr_i (wr_stat & wdata_i[POS]),
      .flag_o(flags_q[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) live_q <= 2'b01;
    else         live_q <= {bat_mid_i, bat_hi_i};
  end

  always_comb begin
    stat_img = '0;
    for (int s = 0; s < NUM_SRC; s++) stat_img[src_pos(s)] = flags_q[s];
    stat_img[LIVE_HI_POS]  = live_q[0];
    stat_img[LIVE_MID_POS] = live_q[1];
  end

  always_comb begin
    case (addr_i)
      OFS_EN:   rd_val = en_q;
      OFS_STAT: rd_val = stat_img;
      default:  rd_val = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_o <= '0;
    else         rdata_o <= rd_req ? rd_val : '0;
  end

  supmon_irq_route u_route (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en_q),
    .flags_i(flags_q),
    .irq_o  (irq_o),
    .nmi_o  (nmi_o)
  );
endmodule

// File: rtl/supmon_irq_chk.sv
module supmon_irq_chk
  import supmon_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic              bat_hi_i,
  input logic              bat_low_i,
  input logic              irq_o,
  input logic              nmi_o,
  input logic [DATA_W-1:0] en_q,
  input logic [NUM_SRC-1:0] flags_q,
  input logic [1:0]        live_q
);
  assert_set_wins_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bat_low_i |=> flags_q[SRC_LOW]);

  assert_clear_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && addr_i == OFS_STAT && wdata_i[0] && !bat_low_i) |=> !flags_q[SRC_LOW]);

  assert_live_lag_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_ni |=> live_q[0] == $past(bat_hi_i));

  assert_irq_masked_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_q[EN_BAND] && !en_q[EN_OV]) |=> !irq_o);

  assert_nmi_masked_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_q[EN_UV] && !en_q[EN_LOW]) |=> !nmi_o);

  assert_rdata_idle_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && !we_i) |=> rdata_o == '0);
endmodule

bind supmon_irq_ctrl supmon_irq_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .req_i    (req_i),
  .we_i     (we_i),
  .addr_i   (addr_i),
  .wdata_i  (wdata_i),
  .rdata_o  (rdata_o),
  .bat_hi_i (bat_hi_i),
  .bat_low_i(bat_low_i),
  .irq_o    (irq_o),
  .nmi_o    (nmi_o),
  .en_q     (en_q),
  .flags_q  (flags_q),
  .live_q   (live_q)
);

// File: tb/supmon_irq_ctrl_test.sv
module supmon_irq_ctrl_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0, we_i = 1'b0;
  logic [3:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic bat_hi_i = 1'b1, bat_mid_i = 1'b0, bat_low_i = 1'b0;
  logic vreg_ov_i = 1'b0, vreg_uv_i = 1'b0;
  logic irq_o, nmi_o;

  int n_cmp = 0, n_bad = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        pend = 1'b0;
  bit          done = 1'b0;

  always #10 clk_i = ~clk_i;  // 50 MHz

  supmon_irq_ctrl uut (.*);

  // monitor: read data arrives the cycle after the request
  always @(posedge clk_i) pend <= req_i & ~we_i;
  always @(negedge clk_i) begin
    if (pend) begin
      logic [31:0] e; string t;
      e = exp_q.pop_front(); t = tag_q.pop_front();
      n_cmp++;
      if (rdata_o !== e) begin
        n_bad++;
        $display("FAIL %s: rdata actual=%h expected=%h", t, rdata_o, e);
      end
    end
  end

  task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk_i); req_i = 1; we_i = 1; addr_i = a; wdata_i = d;
    @(negedge clk_i); req_i = 0; we_i = 0; wdata_i = '0;
  endtask

  task automatic bus_read(input logic [3:0] a, input logic [31:0] e, input string t);
    @(negedge clk_i); req_i = 1; we_i = 0; addr_i = a;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk_i); req_i = 0;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic check_bit(input logic act, input logic e, input string t);
    n_cmp++;
    if (act !== e) begin
      n_bad++;
      $display("FAIL %s: actual=%b expected=%b", t, act, e);
    end
  endtask

  task automatic pulse(ref logic sig);
    @(negedge clk_i); sig = 1;
    @(negedge clk_i); sig = 0;
  endtask

  initial begin
    wait_cyc(3);
    rst_ni = 1;
    // R1 reset image
    bus_read(4'd1, 32'h0000_2100, "R1 status reset");
    bus_read(4'd0, 32'h0, "R1 enable reset");
    check_bit(irq_o, 0, "R1 irq reset");
    check_bit(nmi_o, 0, "R1 nmi reset");
    // R2 writable mask
    bus_write(4'd0, 32'hFFFF_FFFF);
    bus_read(4'd0, 32'h0000_0507, "R2 enable mask");
    wait_cyc(1);
    check_bit(irq_o, 0, "R6 middle band selected, flag clear");
    bus_write(4'd0, 32'h0000_0400);
    wait_cyc(1);
    check_bit(irq_o, 1, "R6 upper band selected, flag set");
    // R5 clear while condition high
    bus_write(4'd1, 32'h0000_0100);
    bus_read(4'd1, 32'h0000_2100, "R5 set beats clear");
    // R4 clear with condition low
    @(negedge clk_i); bat_hi_i = 0;
    wait_cyc(1);
    bus_write(4'd1, 32'h0000_0100);
    bus_read(4'd1, 32'h0, "R4 upper flag cleared");
    wait_cyc(1);
    check_bit(irq_o, 0, "R4 irq drops after clear");
    // R3/R6 middle band
    pulse(bat_mid_i);
    bus_read(4'd1, 32'h0000_0200, "R3 middle flag sticky");
    check_bit(irq_o, 0, "R6 upper selected ignores middle flag");
    bus_write(4'd0, 32'h0000_0500);
    wait_cyc(1);
    check_bit(irq_o, 1, "R6 middle selected");
    bus_write(4'd1, 32'h0000_0200);
    wait_cyc(1);
    check_bit(irq_o, 0, "R4 middle cleared");
    @(negedge clk_i); bat_mid_i = 1;
    wait_cyc(2);
    bus_read(4'd1, 32'h0000_4200, "R3 live middle bit");
    @(negedge clk_i); bat_mid_i = 0;
    wait_cyc(1);
    bus_write(4'd1, 32'h0000_0200);
    // R7 overvoltage
    bus_write(4'd0, 32'h0000_0004);
    pulse(vreg_ov_i);
    wait_cyc(2);
    check_bit(irq_o, 1, "R7 overvoltage irq");
    check_bit(nmi_o, 0, "R7 overvoltage not nmi");
    bus_write(4'd1, 32'h0000_0004);
    wait_cyc(1);
    check_bit(irq_o, 0, "R7 overvoltage cleared");
    // R8 undervoltage, low battery
    bus_write(4'd0, 32'h0000_0002);
    pulse(vreg_uv_i);
    wait_cyc(2);
    check_bit(nmi_o, 1, "R8 undervoltage nmi");
    check_bit(irq_o, 0, "R8 undervoltage not irq");
    bus_write(4'd1, 32'h0000_0002);
    wait_cyc(1);
    check_bit(nmi_o, 0, "R8 undervoltage cleared");
    bus_write(4'd0, 32'h0000_0001);
    pulse(bat_low_i);
    wait_cyc(2);
    check_bit(nmi_o, 1, "R8 low battery nmi");
    bus_read(4'd1, 32'h0000_0001, "R3 low flag");
    // R10 ignored writes
    bus_write(4'd1, 32'hFFFF_FCF8);
    bus_read(4'd1, 32'h0000_0001, "R10 reserved/ro status write");
    bus_write(4'd5, 32'hFFFF_FFFF);
    bus_read(4'd0, 32'h0000_0001, "R10 unmapped write");
    bus_read(4'd5, 32'h0, "R10 unmapped read");
    // R11 idle read data
    wait_cyc(1);
    check_bit(rdata_o == 32'h0, 1, "R11 idle rdata zero");
    // R8 disabled source / R9 timing
    bus_write(4'd1, 32'h0000_0001);
    bus_write(4'd0, 32'h0);
    pulse(vreg_uv_i);
    wait_cyc(2);
    check_bit(nmi_o, 0, "R8 disabled undervoltage");
    bus_read(4'd1, 32'h0000_0002, "R8 disabled flag still sets");
    bus_write(4'd0, 32'h0000_0002);
    check_bit(nmi_o, 0, "R9 nmi not yet");
    wait_cyc(1);
    check_bit(nmi_o, 1, "R9 nmi one cycle later");
    wait_cyc(2);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk_i);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule